// File: doc/BRIEF.md
# Phased Pseudo-Dual-Port Register File

This block gives one write port and one read port, both usable in the same cycle, on top of two single-port storage arrays (array A and array B). A phase bit comes in from outside and toggles on every clock. A write is taken only when the phase equals the `WRITE_PHASE` parameter. On that cycle array A stores the write and a holding register latches it. On the next cycle, the opposite phase, the holding register copies the same lanes into array B. So array B always trails array A by exactly one cycle.

A read can be issued on every cycle. On the write phase, array A's port is busy with the write, so the read goes to array B. On the other phase, array B's port is busy finishing the staggered write, so the read goes to array A. The read result is registered and shows up one clock after the address.

The `TRANSPARENT` parameter decides what a read returns when it hits the address being written in the same cycle. With `TRANSPARENT` set, the read returns the newly written lanes. With it clear, the read returns the word as it was before the write. Each array also has a combinational debug output, and both outputs use one shared debug address.

The holding register is run by a two-state machine:

- IDLE: nothing pending for array B.
- PEND: a captured write is being copied into array B in this cycle.

Its transitions are:

- CAPTURE: IDLE to PEND, taken on an accepted write.
- DRAIN: PEND to IDLE, taken when no new write is accepted.
- RECAPTURE: PEND to PEND, taken on an accepted write while already in PEND. This only happens if the phase fails to toggle.
- REST: IDLE to IDLE.

Synchronous reset forces IDLE.

Top module: `phased_rf`

## Requirements
- R1: A write is accepted only when `rst` is 0, `phase` equals `WRITE_PHASE` (0 or 1), and at least one bit of `wr_we` is 1. Requests on the other phase change neither array.
- R2: Lane i covers data bits [i*LANE_W +: LANE_W], where LANE_W = DATA_W/LANES. A lane whose `wr_we` bit is 0 keeps its previous contents in both arrays.
- R3: An accepted write is visible on `dbg_q_a` right after the clock edge that ends the write cycle. The same lanes appear on `dbg_q_b` exactly one clock later.
- R4: `rd_data` shows the word at the `rd_addr` presented one clock earlier.
- R5: With `TRANSPARENT`=1, a read whose address equals an accepted write's address in the same cycle returns the written lanes, merged with the old contents of the disabled lanes.
- R6: With `TRANSPARENT`=0, such a colliding read returns the word stored before that write.
- R7: `dbg_q_a` and `dbg_q_b` combinationally show the contents of arrays A and B at `dbg_addr`.
- R8: Reads are served on both phases, back to back, with correct data. On the phase off the write phase, the data comes from array A while array B is taking the staggered write.
- R9: Synchronous reset returns the holding register to IDLE. A write accepted in the cycle just before reset never reaches array B, and no write is accepted while `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase | input | 1 | Phase bit, toggles every cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_we | input | LANES | Per-lane write enables |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| dbg_addr | input | ADDR_W | Shared debug address |
| dbg_q_a | output | DATA_W | Array A word at `dbg_addr` |
| dbg_q_b | output | DATA_W | Array B word at `dbg_addr` |

## Verification
The bound checker watches the holding register on every cycle. It checks that off-phase requests leave it IDLE, that an accepted write is captured with its address, that array B's lane enables one cycle later equal the accepted enables, and that reset empties it.

Several behaviours can only be shown by the bench's scenarios, using its behavioural model of both arrays. These are:

- stored data values;
- the one-cycle lag of array B seen through the debug port;
- the transparent and old-data collision results;
- lane masking;
- the fate of a write cut off by reset.

The bench runs two instances, one for each write phase and transparency setting.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic {
        HOLD_IDLE = 1'b0,
        HOLD_PEND = 1'b1
    } hold_state_e;
endpackage

// File: rtl/rf_sram_1rw.sv
module rf_sram_1rw #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    // one array per lane so that every lane has a single writer
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            rdata[g*LANE_W +: LANE_W] <= cells[addr];
        end

        assign dbg_data[g*LANE_W +: LANE_W] = cells[dbg_addr];
    end
endmodule

// File: rtl/rf_hold_fsm.sv
module rf_hold_fsm
    import rf_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_we,
    output hold_state_e       st,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output logic [LANES-1:0]  b_we
);
    hold_state_e       st_nxt;
    logic [LANES-1:0]  hold_en;

    // state register and captured write
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= HOLD_IDLE;
            hold_en <= '0;
        end else begin
            st <= st_nxt;
            if (accept) begin
                hold_en <= wr_we;
            end
        end
        if (accept) begin
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end

    // transitions: CAPTURE, DRAIN, RECAPTURE, REST
    always_comb begin
        st_nxt = st;
        unique case (st)
            HOLD_IDLE: st_nxt = accept ? HOLD_PEND : HOLD_IDLE;
            HOLD_PEND: st_nxt = accept ? HOLD_PEND : HOLD_IDLE;
            default:   st_nxt = HOLD_IDLE;
        endcase
    end

    // outputs: array B write lanes while draining
    always_comb begin
        b_we = '0;
        unique case (st)
            HOLD_IDLE: b_we = '0;
            HOLD_PEND: b_we = rst ? '0 : hold_en;
            default:   b_we = '0;
        endcase
    end
endmodule

// File: rtl/rf_read_merge.sv
module rf_read_merge #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_b_d,
    input  logic [LANES-1:0]  byp_mask_d,
    input  logic [DATA_W-1:0] byp_data_d,
    input  logic [DATA_W-1:0] q_a,
    input  logic [DATA_W-1:0] q_b,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LANE_W = DATA_W / LANES;

    logic              sel_b_q;
    logic [LANES-1:0]  byp_mask_q;
    logic [DATA_W-1:0] byp_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_b_q    <= 1'b0;
            byp_mask_q <= '0;
        end else begin
            sel_b_q    <= sel_b_d;
            byp_mask_q <= byp_mask_d;
        end
        byp_data_q <= byp_data_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (byp_mask_q[g]) begin
                rd_data[g*LANE_W +: LANE_W] = byp_data_q[g*LANE_W +: LANE_W];
            end else if (sel_b_q) begin
                rd_data[g*LANE_W +: LANE_W] = q_b[g*LANE_W +: LANE_W];
            end else begin
                rd_data[g*LANE_W +: LANE_W] = q_a[g*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/phased_rf.sv
module phased_rf
    import rf_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 32,
    parameter int LANES       = 4,
    parameter int WRITE_PHASE = 0,
    parameter bit TRANSPARENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_we,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_q_a,
    output logic [DATA_W-1:0] dbg_q_b
);
    localparam logic WP_BIT = 1'(WRITE_PHASE);

    logic              on_wp;
    logic              accept;
    logic [ADDR_W-1:0] a_addr, b_addr, hold_addr;
    logic [LANES-1:0]  a_we, b_we, byp_mask;
    logic [DATA_W-1:0] q_a, q_b, hold_data;
    hold_state_e       hold_st;

    assign on_wp  = (phase == WP_BIT);
    assign accept = !rst && on_wp && (|wr_we);

    rf_hold_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_we     (wr_we),
        .st        (hold_st),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .b_we      (b_we)
    );

    // array A: written on the write phase, read on the other phase
    assign a_addr = on_wp ? wr_addr : rd_addr;
    assign a_we   = accept ? wr_we : '0;

    // array B: drains the holding register, otherwise read
    assign b_addr = (hold_st == HOLD_PEND) ? hold_addr : rd_addr;

    rf_sram_1rw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr_a (
        .clk      (clk),
        .addr     (a_addr),
        .we       (a_we),
        .wdata    (wr_data),
        .rdata    (q_a),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_q_a)
    );

    rf_sram_1rw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr_b (
        .clk      (clk),
        .addr     (b_addr),
        .we       (b_we),
        .wdata    (hold_data),
        .rdata    (q_b),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_q_b)
    );

    if (TRANSPARENT) begin : g_transp
        assign byp_mask = (accept && (rd_addr == wr_addr)) ? wr_we : '0;
    end else begin : g_old_data
        assign byp_mask = '0;
    end

    rf_read_merge #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .sel_b_d    (on_wp),
        .byp_mask_d (byp_mask),
        .byp_data_d (wr_data),
        .q_a        (q_a),
        .q_b        (q_b),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int LANES       = 4,
    parameter int WRITE_PHASE = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              phase,
    input logic [LANES-1:0]  wr_we,
    input logic [ADDR_W-1:0] wr_addr,
    input hold_state_e       st,
    input logic [ADDR_W-1:0] hold_addr,
    input logic [LANES-1:0]  b_we
);
    localparam logic WP_BIT = 1'(WRITE_PHASE);

    // R1: an off-phase request never loads the holding register
    a_r1_off_phase_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase != WP_BIT) |=> (st == HOLD_IDLE));

    // R3: accepted write is captured with its address
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        ((phase == WP_BIT) && (|wr_we)) |=> ((st == HOLD_PEND) && (hold_addr == $past(wr_addr))));

    // R3: array B gets the same lanes one cycle later
    a_r3_b_lanes: assert property (@(posedge clk) disable iff (rst)
        ((phase == WP_BIT) && (|wr_we)) |=> (b_we == $past(wr_we)));

    // R9: reset empties the holding register
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> ((st == HOLD_IDLE) && (b_we == '0)));
endmodule

bind phased_rf rf_checker #(
    .ADDR_W      (ADDR_W),
    .LANES       (LANES),
    .WRITE_PHASE (WRITE_PHASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .wr_we     (wr_we),
    .wr_addr   (wr_addr),
    .st        (hold_st),
    .hold_addr (hold_addr),
    .b_we      (b_we)
);

// File: tb/phased_rf_bench.sv
module phased_rf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;
    localparam int DW = 32;
    localparam int NL = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, dbg_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] wr_we = '0;
    logic [DW-1:0] rd_o [2];
    logic [DW-1:0] dba_o [2];
    logic [DW-1:0] dbb_o [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    // instance 0: writes on phase 0, transparent
    phased_rf #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL), .WRITE_PHASE(0), .TRANSPARENT(1'b1)) u_phased_rf (
        .clk(clk), .rst(rst), .phase(phase), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_we(wr_we), .rd_addr(rd_addr), .rd_data(rd_o[0]), .dbg_addr(dbg_addr),
        .dbg_q_a(dba_o[0]), .dbg_q_b(dbb_o[0]));

    // instance 1: writes on phase 1, old-data reads
    phased_rf #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL), .WRITE_PHASE(1), .TRANSPARENT(1'b0)) u_phased_rf_nt (
        .clk(clk), .rst(rst), .phase(phase), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_we(wr_we), .rd_addr(rd_addr), .rd_data(rd_o[1]), .dbg_addr(dbg_addr),
        .dbg_q_a(dba_o[1]), .dbg_q_b(dbb_o[1]));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // behavioural model
    logic [DW-1:0] lm [2][DEPTH];
    bit            lv [2][DEPTH];
    logic [DW-1:0] bm [2][DEPTH];
    bit            bv [2][DEPTH];
    bit            pv [2];
    logic [AW-1:0] pa [2];
    logic [DW-1:0] pd [2];
    logic [NL-1:0] pe [2];
    logic [DW-1:0] exp_rd [2];
    bit            exp_v [2];
    string         exp_tag [2];
    string         scen = "";
    logic [AW-1:0] cur_da = '0;
    logic          ph = 1'b0;
    localparam bit WPK [2] = '{1'b0, 1'b1};
    localparam bit TRK [2] = '{1'b1, 1'b0};

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [NL-1:0] en);
        logic [DW-1:0] r = o;
        for (int i = 0; i < NL; i++) begin
            if (en[i]) r[i*8 +: 8] = n[i*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] ex,
                       input string tag, input string what);
        n_tests++;
        if (act !== ex) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, ex, $time);
        end
    endtask

    task automatic step(input logic r, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic [NL-1:0] we, input logic [AW-1:0] ra, input logic [AW-1:0] da);
        // compare outputs of the previous cycle
        for (int k = 0; k < 2; k++) begin
            if (exp_v[k]) chk(rd_o[k], exp_rd[k], exp_tag[k], $sformatf("rd_data inst%0d", k));
            if (lv[k][cur_da]) chk(dba_o[k], lm[k][cur_da], (scen != "") ? scen : "R7",
                                   $sformatf("dbg_q_a inst%0d", k));
            if (bv[k][cur_da]) chk(dbb_o[k], bm[k][cur_da], (scen != "") ? scen : "R3",
                                   $sformatf("dbg_q_b inst%0d", k));
        end
        // drive this cycle
        rst = r; phase = ph; wr_addr = wa; wr_data = wd; wr_we = we;
        rd_addr = ra; dbg_addr = da; cur_da = da;
        for (int k = 0; k < 2; k++) begin
            bit acc = !r && (ph == WPK[k]) && (we != '0);
            bit coll = acc && (ra == wa);
            exp_v[k] = !r && lv[k][ra];
            exp_rd[k] = (coll && TRK[k]) ? mrg(lm[k][ra], wd, we) : lm[k][ra];
            if (coll) exp_tag[k] = TRK[k] ? "R5" : "R6";
            else if (scen != "") exp_tag[k] = scen;
            else exp_tag[k] = (ph != WPK[k]) ? "R8" : "R4";
            // array B takes last cycle's write unless reset cut it off
            if (pv[k] && !r) begin
                bm[k][pa[k]] = mrg(bm[k][pa[k]], pd[k], pe[k]);
                bv[k][pa[k]] = bv[k][pa[k]] || (pe[k] == '1);
            end
            pv[k] = acc; pa[k] = wa; pd[k] = wd; pe[k] = we;
            if (acc) begin
                lm[k][wa] = mrg(lm[k][wa], wd, we);
                lv[k][wa] = lv[k][wa] || (we == '1);
            end
        end
        ph = ~ph;
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            pv[k] = 0; exp_v[k] = 0;
            for (int a = 0; a < DEPTH; a++) begin lv[k][a] = 0; bv[k][a] = 0; end
        end
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, '0, '0, '0, '0, '0);

        // fill every address in both instances (R3)
        for (int c = 0; c < 2*DEPTH; c++) begin
            step(1'b0, AW'(c >> 1), 32'hA500_0000 ^ (c * 32'h0101_0103), 4'hF,
                 AW'((c >> 1) - 1), AW'((c >> 1) - 1));
        end

        // R1: a write presented on only one phase reaches only one instance
        scen = "R1";
        if (ph != 1'b1) step(1'b0, '0, '0, '0, 7'd3, 7'd3);
        step(1'b0, 7'd10, 32'h1111_2222, 4'hF, 7'd10, 7'd10);
        step(1'b0, '0, '0, '0, 7'd10, 7'd10);
        step(1'b0, '0, '0, '0, 7'd10, 7'd10);
        step(1'b0, '0, '0, '0, 7'd10, 7'd10);

        // R2: partial lane writes on both phases
        scen = "R2";
        step(1'b0, 7'd11, 32'hDEAD_BEEF, 4'b1001, 7'd12, 7'd11);
        step(1'b0, 7'd11, 32'hCAFE_F00D, 4'b1001, 7'd12, 7'd11);
        step(1'b0, 7'd12, 32'h0BAD_C0DE, 4'b0110, 7'd11, 7'd12);
        step(1'b0, 7'd12, 32'h5555_AAAA, 4'b0110, 7'd11, 7'd12);
        step(1'b0, '0, '0, '0, 7'd12, 7'd11);
        step(1'b0, '0, '0, '0, 7'd11, 7'd12);
        step(1'b0, '0, '0, '0, 7'd12, 7'd12);

        // R5 / R6: read and write the same address in the same cycle
        scen = "";
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 7'd30, 32'h7000_0000 + i, (i % 3 == 0) ? 4'b0101 : 4'hF, 7'd30, 7'd30);
        end
        step(1'b0, '0, '0, '0, 7'd30, 7'd30);

        // R9: a write accepted just before reset must not reach array B
        scen = "R9";
        for (int t = 0; t < 2; t++) begin
            if (ph != WPK[t]) step(1'b0, '0, '0, '0, 7'd1, 7'(20 + t));
            step(1'b0, 7'(20 + t), 32'hFEED_0000 + t, 4'hF, 7'd1, 7'(20 + t));
            step(1'b1, '0, '0, '0, 7'd1, 7'(20 + t));
            step(1'b0, '0, '0, '0, 7'd2, 7'(20 + t));
            step(1'b0, '0, '0, '0, 7'd2, 7'(20 + t));
        end
        // realign both arrays at the cut-off addresses
        for (int t = 0; t < 4; t++) step(1'b0, 7'(20 + t / 2), 32'h2020_2020 + t, 4'hF, 7'd3, 7'd3);
        step(1'b0, '0, '0, '0, 7'd3, 7'd3);
        for (int k = 0; k < 2; k++) begin
            chk(dba_o[k], dbb_o[k], "R9", "arrays realigned");
        end

        // mixed traffic, reads every cycle (R4, R7, R8)
        scen = "";
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] wa = AW'($urandom);
            logic [AW-1:0] ra = ($urandom % 4 == 0) ? wa : AW'($urandom);
            step(1'b0, wa, $urandom, NL'($urandom), ra, AW'($urandom));
        end
        step(1'b0, '0, '0, '0, '0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule